// File: doc/BRIEF.md
# Adaptive Two-Error BCH Word Corrector

This block corrects a 274-bit received word of a shortened binary BCH code that carries 256 data bits and 18 check bits, with a correction capability of two bit errors. The field is GF(2^9). The whole correction happens in one combinational pass, placed between an input register and an output register. A word offered with `in_valid` produces its 256 corrected data bits and a two-bit outcome code two clock edges later. Words may arrive back to back.

Inside, two XOR-tree syndromes are formed: the first-power sum and the cube-power sum. The locator polynomial is used in a form that needs no division: it is multiplied through by the first syndrome. The value R = S1^3 + S3 sorts the word into one of three classes: clean, one error or two errors. A word with one error is fixed by a direct match of S1 against each position's field element. This short path needs only S1. A word with two errors goes through the full quadratic search, which tests all positions in parallel. R selects which of the two hit vectors is applied to the word. A word whose hits do not fit its class is returned unaltered and flagged.

Top module: `bch2_adaptive_dec`

## Requirements
- R1: While `rst` is high at a rising edge, `out_valid`, `out_status` and `out_data` are cleared to zero at that edge.
- R2: A word sampled with `in_valid` high at a rising edge gives exactly one result: `out_valid` is high after the second following rising edge. `out_valid` is never high for any other reason.
- R3: A word is a codeword when two sums are both zero: the sum of alpha^i and the sum of alpha^(3i), each taken over its set bits i. Here alpha is a root of x^9 + x^4 + 1. Bits 17..0 are check bits and bits 273..18 carry data, with data bit d at word bit 18+d. For a codeword, `out_status` is 0 and `out_data` equals word bits 273..18.
- R4: A codeword with exactly one flipped bit, at any of the 274 positions (check bit or data bit), gives `out_status` = 1 and the original data.
- R5: A codeword with exactly two flipped bits, at any two distinct positions, gives `out_status` = 2 and the original data.
- R6: A word whose first syndrome is zero but whose cube syndrome is not gives `out_status` = 3, and the data bits are passed through unchanged.
- R7: Some words have a nonzero syndrome that no pattern of at most two flips within the 274 positions can explain, because the roots of the locator fall outside the shortened length. Such a word gives `out_status` = 3, and its data bits are passed through unchanged.
- R8: In a cycle where `out_valid` is low, `out_data` and `out_status` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_word` as a word to correct |
| in_word | input | 274 | Received word; bits 17..0 check, 273..18 data |
| out_valid | output | 1 | High for one cycle per corrected word |
| out_data | output | 256 | Corrected (or passed-through) data bits |
| out_status | output | 2 | 0 clean, 1 one fixed, 2 two fixed, 3 uncorrectable |

## Verification
The bench aims at the positions where the shortening and the check/data split meet: positions 0, 17, 18 and 273, alone and in pairs. A wrong field constant or a misplaced data slice shows up there as a flip on the wrong bit. A word built from three flips whose field elements cancel drives S1 to zero with S3 nonzero. A design that trusted S1 alone would report such a word as clean. Random triple-flip words mostly leave locator roots beyond bit 273. A design that counted hits loosely would then apply a one-bit or partial correction instead of flagging the word. Back-to-back words and idle gaps expose results that appear at the wrong latency or outputs that drift between results.

// File: rtl/bch2_pkg.sv
package bch2_pkg;

    localparam int GF_M     = 9;
    localparam int GF_ORDER = (1 << GF_M) - 1;
    // x^9 reduces to x^4 + 1
    localparam logic [GF_M-1:0] GF_FOLD = 9'h011;

    localparam int CW_N = 274;
    localparam int CW_K = 256;
    localparam int CW_P = CW_N - CW_K;

    typedef logic [GF_M-1:0] gf_t;

    typedef struct packed {
        gf_t s3;
        gf_t s1;
    } synd_t;

    typedef enum logic [1:0] {
        ST_CLEAN = 2'd0,
        ST_ONE   = 2'd1,
        ST_TWO   = 2'd2,
        ST_FAIL  = 2'd3
    } dec_status_e;

    typedef enum logic [1:0] {
        CLS_NONE  = 2'd0,
        CLS_ONE   = 2'd1,
        CLS_TWO   = 2'd2,
        CLS_ALIAS = 2'd3
    } err_class_e;

    // multiply by alpha
    function automatic gf_t gf_xtime(gf_t a);
        return {a[GF_M-2:0], 1'b0} ^ (a[GF_M-1] ? GF_FOLD : '0);
    endfunction

    // general product: AND terms folded with XOR
    function automatic gf_t gf_mul(gf_t a, gf_t b);
        gf_t acc = '0;
        gf_t sh  = a;
        for (int k = 0; k < GF_M; k++) begin
            if (b[k]) acc = acc ^ sh;
            sh = gf_xtime(sh);
        end
        return acc;
    endfunction

    // alpha^e, evaluated at elaboration for constants
    function automatic gf_t gf_pow(int e);
        gf_t p = gf_t'(1);
        for (int k = 0; k < (e % GF_ORDER); k++) p = gf_xtime(p);
        return p;
    endfunction

endpackage

// File: rtl/bch2_syndrome.sv
module bch2_syndrome
    import bch2_pkg::*;
#(
    parameter int N = CW_N
) (
    input  logic [N-1:0] word,
    output synd_t        synd
);

    // column mask of one syndrome bit: which word bits feed its XOR tree
    function automatic logic [N-1:0] tap_mask(int bitpos, int step);
        logic [N-1:0] m;
        gf_t p = gf_t'(1);
        m = '0;
        for (int i = 0; i < N; i++) begin
            m[i] = p[bitpos];
            for (int s = 0; s < step; s++) p = gf_xtime(p);
        end
        return m;
    endfunction

    gf_t s1_v;
    gf_t s3_v;

    for (genvar b = 0; b < GF_M; b++) begin : g_tree
        localparam logic [N-1:0] MASK1 = tap_mask(b, 1);
        localparam logic [N-1:0] MASK3 = tap_mask(b, 3);
        assign s1_v[b] = ^(word & MASK1);
        assign s3_v[b] = ^(word & MASK3);
    end

    assign synd = {s3_v, s1_v};

endmodule

// File: rtl/bch2_classify.sv
module bch2_classify
    import bch2_pkg::*;
(
    input  synd_t      synd,
    output gf_t        s1_sq,
    output gf_t        r_term,
    output err_class_e cls
);

    gf_t s1_cube;

    always_comb begin
        s1_sq   = gf_mul(synd.s1, synd.s1);
        s1_cube = gf_mul(s1_sq, synd.s1);
        r_term  = s1_cube ^ synd.s3;
    end

    always_comb begin
        if (synd.s1 == '0) begin
            cls = (synd.s3 == '0) ? CLS_NONE : CLS_ALIAS;
        end else if (r_term == '0) begin
            cls = CLS_ONE;
        end else begin
            cls = CLS_TWO;
        end
    end

endmodule

// File: rtl/bch2_chien.sv
module bch2_chien
    import bch2_pkg::*;
#(
    parameter int N = CW_N
) (
    input  gf_t          s1,
    input  gf_t          s1_sq,
    input  gf_t          r_term,
    output logic [N-1:0] hit_one,
    output logic [N-1:0] hit_two
);

    // Locator scaled by S1: S1 + S1^2 x + R x^2, probed at x = alpha^-i.
    // Times alpha^2i: S1 alpha^2i + S1^2 alpha^i + R == 0 flags bit i.
    for (genvar i = 0; i < N; i++) begin : g_pos
        localparam gf_t A_I  = gf_pow(i);
        localparam gf_t A_2I = gf_pow(2 * i);
        gf_t sum_two;
        assign sum_two    = gf_mul(s1, A_2I) ^ gf_mul(s1_sq, A_I) ^ r_term;
        assign hit_two[i] = (sum_two == '0);
        // short path: with R zero the root is alpha^i == S1
        assign hit_one[i] = (s1 == A_I);
    end

endmodule

// File: rtl/bch2_adaptive_dec.sv
module bch2_adaptive_dec
    import bch2_pkg::*;
#(
    parameter int N = CW_N,
    parameter int K = CW_K
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         in_valid,
    input  logic [N-1:0] in_word,
    output logic         out_valid,
    output logic [K-1:0] out_data,
    output logic [1:0]   out_status
);

    localparam int P     = N - K;
    localparam int CNT_W = $clog2(N + 1);

    function automatic logic [CNT_W-1:0] pop_count(logic [N-1:0] v);
        logic [CNT_W-1:0] c = '0;
        for (int i = 0; i < N; i++) c = c + CNT_W'(v[i]);
        return c;
    endfunction

    logic         vld_q;
    logic [N-1:0] word_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q  <= 1'b0;
            word_q <= '0;
        end else begin
            vld_q <= in_valid;
            if (in_valid) word_q <= in_word;
        end
    end

    synd_t      synd;
    gf_t        s1_sq;
    gf_t        r_term;
    err_class_e cls;
    logic [N-1:0] hit_one;
    logic [N-1:0] hit_two;

    bch2_syndrome #(.N(N)) u_synd (
        .word (word_q),
        .synd (synd)
    );

    bch2_classify u_cls (
        .synd   (synd),
        .s1_sq  (s1_sq),
        .r_term (r_term),
        .cls    (cls)
    );

    bch2_chien #(.N(N)) u_chien (
        .s1      (synd.s1),
        .s1_sq   (s1_sq),
        .r_term  (r_term),
        .hit_one (hit_one),
        .hit_two (hit_two)
    );

    logic [N-1:0]     sel_hits;
    logic [CNT_W-1:0] hit_cnt;
    dec_status_e      st;
    logic [N-1:0]     fix_mask;
    logic [N-1:0]     fixed_word;

    always_comb begin
        sel_hits = (cls == CLS_ONE) ? hit_one : hit_two;
        hit_cnt  = pop_count(sel_hits);
        unique case (cls)
            CLS_NONE:  st = ST_CLEAN;
            CLS_ONE:   st = (hit_cnt == CNT_W'(1)) ? ST_ONE : ST_FAIL;
            CLS_TWO:   st = (hit_cnt == CNT_W'(2)) ? ST_TWO : ST_FAIL;
            default:   st = ST_FAIL;
        endcase
        fix_mask   = (st == ST_ONE || st == ST_TWO) ? sel_hits : '0;
        fixed_word = word_q ^ fix_mask;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_data   <= '0;
            out_status <= 2'd0;
        end else begin
            out_valid <= vld_q;
            if (vld_q) begin
                out_data   <= fixed_word[N-1:P];
                out_status <= st;
            end
        end
    end

endmodule

// File: rtl/bch2_dec_chk.sv
module bch2_dec_chk #(
    parameter int N = 274,
    parameter int K = 256
) (
    input logic         clk,
    input logic         rst,
    input logic         in_valid,
    input logic [N-1:0] in_word,
    input logic         out_valid,
    input logic [K-1:0] out_data,
    input logic [1:0]   out_status
);

    logic [K-1:0] din;
    assign din = in_word[N-1:N-K];

    assert_reset_idle_R1: assert property (@(posedge clk)
        $past(rst) && !rst |-> (!out_valid && out_status == 2'd0 && out_data == '0));

    assert_latency_R2: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(rst, 2) && $past(in_valid, 2)) |-> out_valid);

    assert_no_spurious_R2: assert property (@(posedge clk) disable iff (rst)
        out_valid |-> $past(in_valid, 2));

    assert_clean_pass_R3: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_status == 2'd0) |-> out_data == $past(din, 2));

    assert_one_flip_R4: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_status == 2'd1) |-> $countones(out_data ^ $past(din, 2)) <= 1);

    assert_two_flip_R5: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_status == 2'd2) |-> $countones(out_data ^ $past(din, 2)) <= 2);

    // also covers R7: both uncorrectable kinds return the data untouched
    assert_fail_pass_R6: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_status == 2'd3) |-> out_data == $past(din, 2));

    assert_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> ($stable(out_data) && $stable(out_status)));

endmodule

bind bch2_adaptive_dec bch2_dec_chk #(.N(N), .K(K)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_word    (in_word),
    .out_valid  (out_valid),
    .out_data   (out_data),
    .out_status (out_status)
);

// File: tb/sim_bch2_adaptive_dec.sv
module sim_bch2_adaptive_dec;

    localparam int  N          = 274;
    localparam int  K          = 256;
    localparam int  P          = N - K;
    localparam int  ORD        = 511;
    localparam time CLK_PERIOD = 10;
    localparam int  WATCHDOG   = 100000;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         in_valid = 1'b0;
    logic [N-1:0] in_word = '0;
    logic         out_valid;
    logic [K-1:0] out_data;
    logic [1:0]   out_status;

    bch2_adaptive_dec u0 (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_word    (in_word),
        .out_valid  (out_valid),
        .out_data   (out_data),
        .out_status (out_status)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_checks = 0;
    int n_fail   = 0;

    typedef struct {
        logic [K-1:0] data;
        logic [1:0]   status;
        int           due;
        string        tag;
    } exp_t;
    exp_t sb[$];

    // bench field tables, alpha root of x^9 + x^4 + 1
    logic [8:0] pw[0:ORD-1];
    int         lg[0:ORD];

    function automatic logic [8:0] times_alpha(logic [8:0] a);
        logic [8:0] r;
        r = {a[7:0], 1'b0};
        if (a[8]) r = r ^ 9'b0_0001_0001;
        return r;
    endfunction

    task automatic build_tables();
        logic [8:0] p = 9'd1;
        for (int v = 0; v <= ORD; v++) lg[v] = -1;
        for (int e = 0; e < ORD; e++) begin
            pw[e] = p;
            lg[p] = e;
            p = times_alpha(p);
        end
    endtask

    function automatic logic [17:0] syn(logic [N-1:0] w);
        logic [8:0] a1 = '0;
        logic [8:0] a3 = '0;
        for (int i = 0; i < N; i++) begin
            if (w[i]) begin
                a1 = a1 ^ pw[i];
                a3 = a3 ^ pw[(3 * i) % ORD];
            end
        end
        return {a3, a1};
    endfunction

    task automatic encode(input logic [K-1:0] d, output logic [N-1:0] cw);
        logic [17:0] a[18];
        logic [17:0] rhs;
        logic [17:0] col;
        logic [17:0] t;
        logic        tb;
        rhs = syn({d, {P{1'b0}}});
        for (int b = 0; b < 18; b++) a[b] = '0;
        for (int p = 0; p < P; p++) begin
            col = {pw[(3 * p) % ORD], pw[p]};
            for (int b = 0; b < 18; b++) a[b][p] = col[b];
        end
        for (int c = 0; c < 18; c++) begin
            for (int r = c; r < 18; r++) begin
                if (a[r][c]) begin
                    t = a[r]; a[r] = a[c]; a[c] = t;
                    tb = rhs[r]; rhs[r] = rhs[c]; rhs[c] = tb;
                    break;
                end
            end
            for (int r = 0; r < 18; r++) begin
                if (r != c && a[r][c]) begin
                    a[r]   = a[r] ^ a[c];
                    rhs[r] = rhs[r] ^ rhs[c];
                end
            end
        end
        cw = {d, rhs};
    endtask

    // nearest codeword within two flips over the 274 positions, by search
    task automatic predict(input logic [N-1:0] w, output logic [K-1:0] d,
                           output logic [1:0] st, output string tag);
        logic [17:0]  s;
        logic [8:0]   s1, s3, x2;
        logic [N-1:0] fl;
        int           e, j;
        s  = syn(w);
        s1 = s[8:0];
        s3 = s[17:9];
        fl = '0;
        st = 2'd3;
        if (s1 == '0) begin
            st  = (s3 == '0) ? 2'd0 : 2'd3;
            tag = (s3 == '0) ? "R3" : "R6";
        end else begin
            tag = "R7";
            e = lg[s1];
            if (e < N && pw[(3 * e) % ORD] == s3) begin
                st = 2'd1; fl[e] = 1'b1; tag = "R4";
            end else begin
                for (int i = 0; i < N; i++) begin
                    x2 = s1 ^ pw[i];
                    if (x2 != '0) begin
                        j = lg[x2];
                        if (j < N && j > i && (pw[(3 * i) % ORD] ^ pw[(3 * j) % ORD]) == s3) begin
                            st = 2'd2; fl[i] = 1'b1; fl[j] = 1'b1; tag = "R5";
                            break;
                        end
                    end
                end
            end
        end
        d = (w ^ fl) >> P;
    endtask

    task automatic send(input logic [N-1:0] w);
        exp_t it;
        @(negedge clk);
        predict(w, it.data, it.status, it.tag);
        it.due = cyc + 2;
        sb.push_back(it);
        in_valid = 1'b1;
        in_word  = w;
    endtask

    task automatic idle(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            in_valid = 1'b0;
        end
    endtask

    function automatic logic [K-1:0] rand_data();
        logic [K-1:0] d;
        for (int k = 0; k < K / 32; k++) d[k*32 +: 32] = $urandom;
        return d;
    endfunction

    function automatic logic [N-1:0] flip(logic [N-1:0] w, int p);
        logic [N-1:0] r = w;
        r[p] = ~r[p];
        return r;
    endfunction

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    // monitor: compare each result with the front of the scoreboard
    always @(negedge clk) begin
        if (!rst && out_valid) begin
            n_checks++;
            if (sb.size() == 0) begin
                n_fail++;
                $display("FAIL R2: unexpected result status=%0d expected=no result", out_status);
            end else begin
                exp_t it;
                it = sb.pop_front();
                if (out_status !== it.status || out_data !== it.data || cyc != it.due) begin
                    n_fail++;
                    $display("FAIL %s (R2 latency): status=%0d expected=%0d data=%h expected=%h cycle=%0d expected=%0d",
                             it.tag, out_status, it.status, out_data, it.data, cyc, it.due);
                end
            end
        end
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL R2: watchdog expired, pending=%0d expected=0", sb.size());
        report();
        $finish;
    end

    initial begin
        logic [N-1:0] cw;
        logic [N-1:0] w;
        logic [K-1:0] held_d;
        logic [1:0]   held_s;
        int           a, b, c;
        bit           found;

        build_tables();
        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1: reset state
        n_checks++;
        if (out_valid !== 1'b0 || out_status !== 2'd0 || out_data !== '0) begin
            n_fail++;
            $display("FAIL R1: valid=%b status=%0d data=%h expected=0 0 0", out_valid, out_status, out_data);
        end

        // R3: clean codewords, back to back
        encode('0, cw);
        send(cw);
        for (int k = 0; k < 3; k++) begin
            encode(rand_data(), cw);
            send(cw);
        end
        idle(4);

        // R8: outputs hold while idle
        @(negedge clk);
        held_d = out_data;
        held_s = out_status;
        idle(3);
        n_checks++;
        if (out_valid !== 1'b0 || out_data !== held_d || out_status !== held_s) begin
            n_fail++;
            $display("FAIL R8: data=%h status=%0d expected=%h %0d", out_data, out_status, held_d, held_s);
        end

        // R4: single flips, boundary positions then random
        encode(rand_data(), cw);
        send(flip(cw, 0));
        send(flip(cw, 17));
        send(flip(cw, 18));
        send(flip(cw, 273));
        for (int k = 0; k < 10; k++) begin
            encode(rand_data(), cw);
            send(flip(cw, $urandom_range(N - 1)));
        end
        idle(4);

        // R5: double flips, boundaries then random
        encode(rand_data(), cw);
        send(flip(flip(cw, 0), 273));
        send(flip(flip(cw, 17), 18));
        send(flip(flip(cw, 0), 1));
        send(flip(flip(cw, 272), 273));
        for (int k = 0; k < 10; k++) begin
            encode(rand_data(), cw);
            a = $urandom_range(N - 1);
            b = (a + 1 + $urandom_range(N - 2)) % N;
            send(flip(flip(cw, a), b));
        end
        idle(4);

        // R6: three flips whose field elements cancel, so S1 = 0
        found = 0;
        for (int bb = 1; bb < N && !found; bb++) begin
            c = lg[pw[0] ^ pw[bb]];
            if (c > bb && c < N) begin
                w = '0;
                w[0] = 1'b1; w[bb] = 1'b1; w[c] = 1'b1;
                if (syn(w)[17:9] != '0) begin
                    found = 1;
                    encode(rand_data(), cw);
                    send(cw ^ w);
                end
            end
        end
        idle(4);

        // R7 (and any R4/R5 aliases): random triple flips
        for (int k = 0; k < 30; k++) begin
            encode(rand_data(), cw);
            a = $urandom_range(N - 1);
            b = (a + 1 + $urandom_range(N - 2)) % N;
            do c = $urandom_range(N - 1); while (c == a || c == b);
            send(flip(flip(flip(cw, a), b), c));
        end
        idle(6);

        n_checks++;
        if (sb.size() != 0) begin
            n_fail++;
            $display("FAIL R2: pending results=%0d expected=0", sb.size());
        end
        report();
        $finish;
    end

endmodule